// File: doc/BRIEF.md
# Byte-to-Word Width-Converting FIFO

This block is a single-clock FIFO that takes bytes on its write side and hands out 16-bit words on its read side. It lets a byte-wide producer, such as a converter that emits one sample per cycle, feed a consumer that takes two bytes at a time. Each pair of bytes is packed into one storage word. Storage is a small memory of 16-bit words indexed by two binary counters. A single lap bit records whether the write counter has wrapped once more than the read counter.

Both sides share one clock. The byte side can be strobed every cycle while the word side is strobed every other cycle, and the two rates then balance. Empty and full flags are decoded from the counters and the lap bit. A request that a flag forbids is dropped. Read data comes from a register that loads only on an accepted read.

Top module: `wconv_fifo`

## Requirements
- R1: The first accepted byte of a pair lands in bits [7:0] of the stored word and the second accepted byte lands in bits [15:8].
- R2: Words leave the read port in the order their pairs were completed.
- R3: `empty` is high exactly when no complete word is stored. A lone first byte of an unfinished pair leaves `empty` high.
- R4: `full` is high exactly when 7 words are stored. The capacity is one less than the 8 memory slots.
- R5: A byte strobed while `full` is high is dropped. It does not change the stored words, and it does not change which half the next accepted byte fills.
- R6: A read strobed while `empty` is high is dropped. `rd_word` keeps its value and no word is consumed.
- R7: After an accepted read, `rd_word` shows the word on the next rising edge. Without an accepted read, `rd_word` holds its value.
- R8: Ordering and flags stay correct across repeated wraps of both counters.
- R9: Synchronous reset (`rst` high at a rising edge) empties the FIFO, sets `rd_word` to 0 and discards a half-written pair.
- R10: An accepted write and an accepted read in the same cycle both take effect. With a byte every cycle and a read every other cycle, the fill level stays steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_byte | input | 8 | Byte to store |
| rd_en | input | 1 | Word read strobe |
| rd_word | output | 16 | Registered read word |
| empty | output | 1 | No complete word stored |
| full | output | 1 | Seven words stored |

## Verification
The assertions assume that the strobes and the byte are known, two-valued levels after reset. They also assume that each strobe is a request the block is free to refuse, so that a strobe raised against a flag is legal input. The bench changes every input at the falling edge and samples at the next falling edge, so each value is stable around the rising edge that uses it. The bench deliberately strobes writes into a full FIFO and reads from an empty one, so the refusal paths are exercised inside this set of assumptions.

// File: rtl/wcf_pkg.sv
package wcf_pkg;

  // Pointer update selected by the {pop, push} pair
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } wcf_op_e;

endpackage

// File: rtl/wcf_packer.sv
module wcf_packer #(
  parameter int IN_W  = 8,
  parameter int RATIO = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take,
  input  logic [IN_W-1:0]       din,
  output logic                  word_we,
  output logic [IN_W*RATIO-1:0] word,
  output logic                  pair_open
);
  localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);
  localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

  logic [PH_W-1:0] phase;
  logic            last;
  logic [IN_W-1:0] hold [RATIO-1];

  assign last = (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (take)
      phase <= last ? '0 : phase + PH_ONE;
  end

  // One holding lane for each byte that waits for the final byte of the word
  for (genvar i = 0; i < RATIO - 1; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        hold[i] <= '0;
      else if (take && phase == PH_W'(i))
        hold[i] <= din;
    end
    assign word[i*IN_W +: IN_W] = hold[i];
  end

  // The final byte goes straight into the top lane
  assign word[(RATIO-1)*IN_W +: IN_W] = din;
  assign word_we   = take && last;
  assign pair_open = (phase != '0);

  // R1: a completed word always leaves the packer at lane zero
  a_r1_phase_restarts: assert property (@(posedge clk) disable iff (rst)
    word_we |=> !pair_open);

endmodule

// File: rtl/wcf_ptrs.sv
module wcf_ptrs
  import wcf_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] wr_idx,
  output logic [ADDR_W-1:0] rd_idx,
  output logic              empty,
  output logic              full
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic    lap;
  logic    wr_last, rd_last;
  wcf_op_e op;

  assign wr_last = (wr_idx == '1);
  assign rd_last = (rd_idx == '1);
  assign op      = wcf_op_e'({pop, push});

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      lap    <= 1'b0;
    end else begin
      unique case (op)
        OP_PUSH: begin
          wr_idx <= wr_idx + ONE;
          lap    <= lap ^ wr_last;
        end
        OP_POP: begin
          rd_idx <= rd_idx + ONE;
          lap    <= lap ^ rd_last;
        end
        OP_BOTH: begin
          wr_idx <= wr_idx + ONE;
          rd_idx <= rd_idx + ONE;
          lap    <= lap ^ wr_last ^ rd_last;
        end
        default: ;
      endcase
    end
  end

  // Equal counters with no lap mean nothing is stored. The counter one step
  // ahead of the write side, with the lap it would carry, meeting the read
  // counter means only the reserved slot is free.
  assign empty = (wr_idx == rd_idx) && !lap;
  assign full  = ((wr_idx + ONE) == rd_idx) && (lap ^ wr_last);

  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));
  a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);
  a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);

endmodule

// File: rtl/wcf_store.sv
module wcf_store #(
  parameter int W      = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (re)
      rdata <= mem[raddr];
  end

  a_r7_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));

endmodule

// File: rtl/wconv_fifo.sv
module wconv_fifo #(
  parameter int IN_W   = 8,
  parameter int RATIO  = 2,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IN_W-1:0]       wr_byte,
  input  logic                  rd_en,
  output logic [IN_W*RATIO-1:0] rd_word,
  output logic                  empty,
  output logic                  full
);
  localparam int OUT_W = IN_W * RATIO;

  logic              take, pop, word_we, pair_open;
  logic [OUT_W-1:0]  word;
  logic [ADDR_W-1:0] wr_idx, rd_idx;

  assign take = wr_en && !full;
  assign pop  = rd_en && !empty;

  wcf_packer #(.IN_W(IN_W), .RATIO(RATIO)) u_packer (
    .clk(clk), .rst(rst), .take(take), .din(wr_byte),
    .word_we(word_we), .word(word), .pair_open(pair_open)
  );

  wcf_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk(clk), .rst(rst), .push(word_we), .pop(pop),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .empty(empty), .full(full)
  );

  wcf_store #(.W(OUT_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .we(word_we), .waddr(wr_idx), .wdata(word),
    .re(pop), .raddr(rd_idx), .rdata(rd_word)
  );

  a_r5_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> ($stable(wr_idx) && $stable(pair_open) && full));
  a_r6_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> ($stable(rd_word) && $stable(rd_idx)));
  a_r3_lone_byte_keeps_empty: assert property (@(posedge clk) disable iff (rst)
    (empty && !pair_open && wr_en) |=> empty);

endmodule

// File: tb/tb_wconv_fifo.sv
module tb_wconv_fifo;
  localparam int CLK_P  = 10;
  localparam int CAP    = 7;
  localparam int NROWS  = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_word;
  logic        empty, full;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] mq [$];
  logic [7:0]  mpend;
  bit          mph;
  logic [15:0] exp_rd;

  // Row: wr, byte, rd, exp_empty, exp_full, check_rd, exp_word
  localparam logic [28:0] TBL [NROWS] = '{
    {1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b1, 8'h44, 1'b1, 1'b0, 1'b0, 1'b1, 16'h2211},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 16'h4433},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 16'h4433},
    {1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 16'h5AA5}
  };

  wconv_fifo dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .rd_en(rd_en), .rd_word(rd_word), .empty(empty), .full(full)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Called at a falling edge; drives, waits one rising edge, checks at the next fall
  task automatic cyc(input logic w, input logic [7:0] b, input logic r, input string tag);
    bit acc_r, acc_w;
    acc_r = r && (mq.size() != 0);
    acc_w = w && (mq.size() != CAP);
    wr_en = w; wr_byte = b; rd_en = r;
    @(posedge clk);
    if (acc_r) exp_rd = mq.pop_front();
    if (acc_w) begin
      if (!mph) begin mpend = b; mph = 1'b1; end
      else begin mq.push_back({b, mpend}); mph = 1'b0; end
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(empty == (mq.size() == 0), "R3 empty flag", 16'(empty), 16'(mq.size() == 0));
    check(full == (mq.size() == CAP), "R4 full flag", 16'(full), 16'(mq.size() == CAP));
    check(rd_word == exp_rd, tag, rd_word, exp_rd);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mq.delete(); mph = 1'b0; exp_rd = '0;
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    report();
  end

  initial begin
    mph = 1'b0; exp_rd = '0;
    @(negedge clk);
    do_reset();
    // R9: reset state
    check(empty === 1'b1, "R9 empty after reset", 16'(empty), 16'h1);
    check(full === 1'b0, "R9 full after reset", 16'(full), 16'h0);
    check(rd_word === 16'h0, "R9 rd_word after reset", rd_word, 16'h0);

    // Table walk: packing (R1), latency (R7), empty-read ignored (R6)
    for (int i = 0; i < NROWS; i++) begin
      logic [28:0] v;
      v = TBL[i];
      cyc(v[28], v[27:20], v[19], "R7 read data");
      check(empty == v[18], "R3 table empty", 16'(empty), 16'(v[18]));
      check(full == v[17], "R4 table full", 16'(full), 16'(v[17]));
      if (v[16]) check(rd_word == v[15:0], "R1 R6 table word", rd_word, v[15:0]);
    end

    // R4 and R5: fill to capacity, strobe while full, then check packing stays aligned
    for (int k = 0; k < 2 * CAP; k++) cyc(1'b1, 8'(8'h30 + k), 1'b0, "R2 fill");
    check(full === 1'b1, "R4 full at seven words", 16'(full), 16'h1);
    cyc(1'b1, 8'hFF, 1'b0, "R5 write while full");
    cyc(1'b1, 8'hFE, 1'b0, "R5 write while full");
    check(full === 1'b1, "R5 still full", 16'(full), 16'h1);
    cyc(1'b1, 8'hFD, 1'b1, "R5 read+write while full");
    check(rd_word === 16'h3130, "R2 first word out", rd_word, 16'h3130);
    cyc(1'b1, 8'hC1, 1'b0, "R5 refill low");
    cyc(1'b1, 8'hC2, 1'b0, "R5 refill high");
    for (int k = 0; k < CAP; k++) cyc(1'b0, 8'h00, 1'b1, "R2 drain order");
    check(rd_word === 16'hC2C1, "R5 pair after refused bytes", rd_word, 16'hC2C1);
    check(empty === 1'b1, "R3 drained", 16'(empty), 16'h1);

    // R3: a lone byte keeps empty
    cyc(1'b1, 8'h77, 1'b0, "R3 lone byte");
    check(empty === 1'b1, "R3 lone byte keeps empty", 16'(empty), 16'h1);
    cyc(1'b1, 8'h88, 1'b0, "R3 pair done");
    cyc(1'b0, 8'h00, 1'b1, "R3 read pair");
    check(rd_word === 16'h8877, "R1 second pair", rd_word, 16'h8877);

    // R8 and R10: byte every cycle, read every other cycle, across many wraps
    for (int k = 0; k < 6; k++) cyc(1'b1, 8'(k + 1), 1'b0, "R10 backlog");
    for (int k = 0; k < 96; k++) cyc(1'b1, 8'(k * 7 + 5), k[0], "R8 wrap stream");
    check(mq.size() == 3 && empty === 1'b0, "R10 steady level", 16'(mq.size()), 16'h3);
    while (mq.size() != 0) cyc(1'b0, 8'h00, 1'b1, "R8 final drain");
    check(empty === 1'b1, "R8 empty after wraps", 16'(empty), 16'h1);

    // R9: reset discards a half-written pair
    cyc(1'b1, 8'hEE, 1'b0, "R9 pending");
    do_reset();
    check(empty === 1'b1 && rd_word === 16'h0, "R9 cleared", rd_word, 16'h0);
    cyc(1'b1, 8'h01, 1'b0, "R9 low");
    cyc(1'b1, 8'h02, 1'b0, "R9 high");
    cyc(1'b0, 8'h00, 1'b1, "R9 read");
    check(rd_word === 16'h0201, "R9 pending byte discarded", rd_word, 16'h0201);

    report();
  end
endmodule